// File: doc/BRIEF.md
# EEPROM Write Buffer and Program Controller

This block sits behind a serial bus slave engine of a 2 KiB EEPROM. The bus engine reports each transaction event as a one-cycle strobe: a START, the received byte address, every received data byte and the STOP. The block keeps the data bytes of one write transaction in a 16-slot row buffer. It applies the rules of the selected write mode and tells the bus engine, through a level output, whether the next data byte may be acknowledged. When the STOP arrives, it runs a self-timed program cycle. During that cycle it commits the buffered bytes to a synchronous memory array and holds `busy_o` high.

A pin selects between two write modes. In row mode the address low nibble wraps inside one 16-byte row. In burst mode up to eight consecutive bytes are accepted from any start address. If a burst crosses a row boundary, its program time is doubled. A write-inhibit pin blocks a whole transaction when it is seen high during the opening part of that transaction. A protected region can also be set at the top of memory. Its floor lies on a 16-byte step inside an upper block that two pins select, and the step and an enable flag come from the byte stored at the highest address. The block keeps a shadow copy of those fields of that byte. It refreshes the shadow whenever its own program cycle writes that address.

Top module: `eeprom_write_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `ack_ok_o` and `mem_we_o` are all low. The shadow pointer is 8'hFF, so no region is protected.
- R2: With `mode_i` low when the address strobe arrives (row mode), data byte k goes to address {addr[10:4], (addr[3:0]+k) mod 16}. After 16 bytes a later byte overwrites the earlier slot that has the same low nibble.
- R3: A STOP in the data phase with at least one byte buffered starts a program cycle, and `busy_o` stays high for exactly PROG_CYC clock cycles. A STOP with no byte buffered starts no cycle. `mem_we_o` is only high while `busy_o` is high.
- R4: With `mode_i` high when the address strobe arrives (burst mode), data byte k goes to address addr+k. When the first and last stored addresses lie in different 16-byte rows, `busy_o` stays high for 2*PROG_CYC cycles.
- R5: In burst mode, every data byte of an uninhibited transaction is granted an acknowledge. Bytes after the eighth are discarded.
- R6: A single-byte write stores the byte at its address and takes PROG_CYC cycles in either mode.
- R7: If `wc_i` is high in any cycle from the START strobe up to and including the address strobe, `ack_ok_o` stays low for the data phase. No array write follows, and no program cycle starts.
- R8: Protection is active when `pre_i` is high and bit 2 of the shadow byte is 0. Then every address from {1'b1, pb_i, shadow[7:4], 4'h0} up to 7FFh is dropped byte by byte, while the unprotected bytes of the same transaction are still written. The encoding of `pb_i` is 00=400h, 01=500h, 10=600h and 11=700h.
- R9: With `pre_i` low, or with shadow bit 2 set, every address including 7FFh is writable. A committed write to 7FFh updates the shadow byte.
- R10: While `busy_o` is high, all strobes are ignored and `ack_ok_o` is low. `ack_ok_o` is high only in the data phase of an uninhibited transaction.
- R11: A START strobe before the STOP discards the bytes buffered so far, so a dummy write commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 1 | Write mode select: 0 row mode, 1 burst mode (sampled with the address strobe) |
| wc_i | input | 1 | Write inhibit, active high |
| pre_i | input | 1 | Protection enable pin |
| pb_i | input | 2 | Selects the upper block holding the protection floor |
| start_i | input | 1 | START condition strobe |
| addr_vld_i | input | 1 | Byte address received strobe |
| addr_i | input | 11 | Full byte address (block bits and byte address) |
| data_vld_i | input | 1 | Data byte received strobe |
| data_i | input | 8 | Received data byte |
| stop_i | input | 1 | STOP condition strobe |
| ack_ok_o | output | 1 | The next data byte may be acknowledged |
| busy_o | output | 1 | Program cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 11 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The bench targets the corners where the rules meet. A row-mode write of 18 bytes starting two below a row end must wrap and overwrite the first two slots; a design that carried into the upper address bits would spill into the next row. An 8-byte burst that straddles a row must take double time and must drop its ninth and tenth bytes while still acknowledging them; a design that kept them or withheld the acknowledge is caught. The protection tests place a burst across the floor and move the floor by changing the block select. They also rewrite the pointer byte to clear protection, so an off-by-one on the floor, a wrong block mapping or a stale shadow shows up as a wrong array byte. Strobes sent during a program cycle, an inhibit pulse seen only at START, and a repeated START after a buffered byte must all leave memory untouched.

// File: rtl/ewb_pkg.sv
// Package: shared geometry and types of the EEPROM write buffer.
// Assumes an 11-bit byte address split into a 3-bit block, 4-bit row and
// 4-bit slot, with 8-bit data.
package ewb_pkg;
    localparam int ADDR_W    = 11;
    localparam int DATA_W    = 8;
    localparam int ROW_BYTES = 16;
    localparam int MB_MAX    = 8;
    localparam int ROW_W     = $clog2(ROW_BYTES);
    localparam int ROWID_W   = ADDR_W - ROW_W;
    localparam int STEP_W    = ROWID_W - 3;
    localparam int MB_W      = $clog2(MB_MAX + 1);
    localparam int FLAG_BIT  = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_t;
endpackage

// File: rtl/ewb_row_buffer.sv
// Row buffer: N byte slots, each with a valid flag.
// Assumes clr and wr never come in the same cycle (the controller gates them).
module ewb_row_buffer #(
    parameter int N  = 16,
    parameter int DW = 8,
    localparam int SW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr,
    input  logic [SW-1:0]   slot,
    input  logic [DW-1:0]   wdata,
    output logic [N-1:0]    vld,
    output logic [N*DW-1:0] data
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        // Purpose: hold one buffered byte and its valid flag.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                vld[i]            <= 1'b0;
                data[i*DW +: DW]  <= '0;
            end else if (wr && slot == SW'(i)) begin
                vld[i]            <= 1'b1;
                data[i*DW +: DW]  <= wdata;
            end
        end
    end
endmodule

// File: rtl/ewb_prot_check.sv
// Protection decision for one row address.
// Assumes the caller passes the row part of the address (block + row) and the
// floor step nibble and enable flag from the shadow pointer byte.
module ewb_prot_check
    import ewb_pkg::*;
(
    input  logic [ROWID_W-1:0] row_addr,
    input  logic               pre,
    input  logic [1:0]         blk_sel,
    input  logic [STEP_W-1:0]  step,
    input  logic               flag_n_dis,
    output logic               hit
);
    logic [ROWID_W-1:0] floor_row;

    // Purpose: compare the row against the protected floor when protection is on.
    always_comb begin
        floor_row = {1'b1, blk_sel, step};
        hit       = pre && !flag_n_dis && (row_addr >= floor_row);
    end
endmodule

// File: rtl/ewb_prog_timer.sv
// Self-timed program cycle counter: single or double length.
// Assumes PROG_CYC is larger than the number of row slots, so that all commit
// beats fall inside the cycle.
module ewb_prog_timer #(
    parameter int PROG_CYC = 500000,
    localparam int CNT_W = $clog2(2 * PROG_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             dbl,
    output logic             busy,
    output logic [CNT_W-1:0] idx
);
    logic [CNT_W-1:0] lim_q;

    // Purpose: run the cycle counter from go until its selected limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx   <= '0;
            lim_q <= '0;
        end else if (!busy) begin
            if (go) begin
                busy  <= 1'b1;
                idx   <= '0;
                lim_q <= dbl ? CNT_W'(2 * PROG_CYC - 1) : CNT_W'(PROG_CYC - 1);
            end
        end else if (idx == lim_q) begin
            busy <= 1'b0;
        end else begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_write_ctrl.sv
// EEPROM write buffer and program controller (top).
// Collects data bytes of one write transaction, applies row/burst mode rules,
// write inhibit and region protection, then commits during a timed cycle.
// Assumes one-cycle strobes from the bus engine, and pre_i/pb_i held stable
// during a program cycle.
module eeprom_write_ctrl
    import ewb_pkg::*;
#(
    parameter int PROG_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              wc_i,
    input  logic              pre_i,
    input  logic [1:0]        pb_i,
    input  logic              start_i,
    input  logic              addr_vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_vld_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              stop_i,
    output logic              ack_ok_o,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    localparam int CNT_W = $clog2(2 * PROG_CYC + 1);
    localparam logic [ROW_W+1:0] ROW_LIM = (ROW_W+2)'(ROW_BYTES);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    phase_t                 phase_q;
    logic                   wc_blk_q;
    logic [ADDR_W-1:0]      base_q;
    logic                   mode_q;
    logic [ROW_W-1:0]       off_q;
    logic [MB_W-1:0]        mb_cnt_q;
    logic [STEP_W-1:0]      sh_step_q;
    logic                   sh_flag_q;

    logic                   buf_clr, buf_wr;
    logic [ROW_W-1:0]       buf_slot;
    logic [ROW_BYTES-1:0]   buf_vld;
    logic [ROW_BYTES*DATA_W-1:0] buf_data;

    logic                   go, dbl;
    logic [ROW_W+1:0]       span;
    logic [CNT_W-1:0]       tidx;
    logic                   issue;
    logic [ROW_W-1:0]       c_slot;
    logic [ADDR_W-1:0]      c_addr;
    logic [DATA_W-1:0]      c_data;
    logic                   c_prot, c_we;
    logic                   accept_byte;

    // Purpose: decode this cycle's buffer write, clear and cycle start.
    always_comb begin
        accept_byte = !busy_o && !start_i && phase_q == PH_DATA && data_vld_i && !wc_blk_q;
        buf_clr  = !busy_o && start_i;
        buf_wr   = accept_byte && (!mode_q || mb_cnt_q < MB_W'(MB_MAX));
        buf_slot = mode_q ? ROW_W'(mb_cnt_q) : off_q;
        go       = !busy_o && !start_i && phase_q == PH_DATA && stop_i && (|buf_vld);
        span     = (ROW_W+2)'(base_q[ROW_W-1:0]) + (ROW_W+2)'(mb_cnt_q) - 1'b1;
        dbl      = mode_q && (span >= ROW_LIM);
    end

    // Purpose: transaction phase, inhibit latch, base address and byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            wc_blk_q <= 1'b0;
            base_q   <= '0;
            mode_q   <= 1'b0;
            off_q    <= '0;
            mb_cnt_q <= '0;
        end else if (!busy_o) begin
            if (start_i) begin
                phase_q  <= PH_ADDR;
                wc_blk_q <= wc_i;
            end else begin
                case (phase_q)
                    PH_ADDR: begin
                        if (wc_i) wc_blk_q <= 1'b1;
                        if (addr_vld_i) begin
                            base_q   <= addr_i;
                            mode_q   <= mode_i;
                            off_q    <= addr_i[ROW_W-1:0];
                            mb_cnt_q <= '0;
                            phase_q  <= PH_DATA;
                        end
                        if (stop_i) phase_q <= PH_IDLE;
                    end
                    PH_DATA: begin
                        if (accept_byte) begin
                            if (!mode_q) off_q <= off_q + 1'b1;
                            else if (mb_cnt_q < MB_W'(MB_MAX)) mb_cnt_q <= mb_cnt_q + 1'b1;
                        end
                        if (stop_i) phase_q <= PH_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    ewb_row_buffer #(.N(ROW_BYTES), .DW(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .wr    (buf_wr),
        .slot  (buf_slot),
        .wdata (data_i),
        .vld   (buf_vld),
        .data  (buf_data)
    );

    ewb_prog_timer #(.PROG_CYC(PROG_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .dbl   (dbl),
        .busy  (busy_o),
        .idx   (tidx)
    );

    // Purpose: pick the slot, address and data of the current commit beat.
    always_comb begin
        issue  = busy_o && (tidx < CNT_W'(ROW_BYTES));
        c_slot = tidx[ROW_W-1:0];
        c_addr = mode_q ? (base_q + ADDR_W'(c_slot)) : {base_q[ADDR_W-1:ROW_W], c_slot};
        c_data = buf_data[c_slot*DATA_W +: DATA_W];
    end

    ewb_prot_check u_prot (
        .row_addr   (c_addr[ADDR_W-1:ROW_W]),
        .pre        (pre_i),
        .blk_sel    (pb_i),
        .step       (sh_step_q),
        .flag_n_dis (sh_flag_q),
        .hit        (c_prot)
    );

    assign c_we = issue && buf_vld[c_slot] && !c_prot;

    // Purpose: register the array write port and refresh the pointer shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_wdata_o <= '0;
            sh_step_q   <= '1;
            sh_flag_q   <= 1'b1;
        end else begin
            mem_we_o    <= c_we;
            mem_addr_o  <= c_addr;
            mem_wdata_o <= c_data;
            if (c_we && c_addr == TOP_ADDR) begin
                sh_step_q <= c_data[DATA_W-1 -: STEP_W];
                sh_flag_q <= c_data[FLAG_BIT];
            end
        end
    end

    // Purpose: grant acknowledges only while collecting an uninhibited write.
    assign ack_ok_o = (phase_q == PH_DATA) && !wc_blk_q && !busy_o;
endmodule

// File: rtl/eeprom_write_ctrl_chk.sv
// Checker for eeprom_write_ctrl: port-level timing properties.
// Assumes the same PROG_CYC as the checked instance.
module eeprom_write_ctrl_chk #(
    parameter int PROG_CYC = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic wc_i,
    input logic start_i,
    input logic addr_vld_i,
    input logic stop_i,
    input logic ack_ok_o,
    input logic busy_o,
    input logic mem_we_o
);
    localparam int BW = $clog2(2 * PROG_CYC + 2);
    logic [BW-1:0] bcnt;

    // Purpose: count consecutive busy cycles for the cycle-length check.
    always_ff @(posedge clk) begin
        if (!rst_n) bcnt <= '0;
        else if (busy_o) bcnt <= bcnt + 1'b1;
        else bcnt <= '0;
    end

    a_r3_prog_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (bcnt == BW'(PROG_CYC) || bcnt == BW'(2 * PROG_CYC)));

    a_r3_we_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    a_r10_ack_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok_o |-> !busy_o);

    a_r7_wc_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_i && wc_i && !busy_o && !start_i) |=> !ack_ok_o);

    a_r3_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o) |=> !ack_ok_o);
endmodule

bind eeprom_write_ctrl eeprom_write_ctrl_chk #(.PROG_CYC(PROG_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wc_i       (wc_i),
    .start_i    (start_i),
    .addr_vld_i (addr_vld_i),
    .stop_i     (stop_i),
    .ack_ok_o   (ack_ok_o),
    .busy_o     (busy_o),
    .mem_we_o   (mem_we_o)
);

// File: tb/eeprom_write_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results
// against a behavioural array model fed from the write port.
module eeprom_write_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0, wc_i = 1'b0, pre_i = 1'b0;
    logic [1:0]  pb_i = 2'b00;
    logic        start_i = 1'b0, addr_vld_i = 1'b0, data_vld_i = 1'b0, stop_i = 1'b0;
    logic [10:0] addr_i = '0;
    logic [7:0]  data_i = '0;
    logic        ack_ok_o, busy_o, mem_we_o;
    logic [10:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;

    int n_chk = 0, n_bad = 0, n_wr = 0;
    bit done = 0;
    logic [7:0] mdl [0:2047];

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_write_ctrl #(.PROG_CYC(P)) u_eeprom_write_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wc_i(wc_i), .pre_i(pre_i),
        .pb_i(pb_i), .start_i(start_i), .addr_vld_i(addr_vld_i), .addr_i(addr_i),
        .data_vld_i(data_vld_i), .data_i(data_i), .stop_i(stop_i),
        .ack_ok_o(ack_ok_o), .busy_o(busy_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    initial for (int i = 0; i < 2048; i++) mdl[i] = 8'hFF;

    always @(posedge clk) if (rst_n && mem_we_o) begin
        mdl[mem_addr_o] <= mem_wdata_o;
        n_wr <= n_wr + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic send_start();
        start_i = 1; @(negedge clk); start_i = 0;
    endtask
    task automatic send_addr(input logic [10:0] a);
        addr_i = a; addr_vld_i = 1; @(negedge clk); addr_vld_i = 0;
    endtask
    task automatic send_data(input logic [7:0] d);
        data_i = d; data_vld_i = 1; @(negedge clk); data_vld_i = 0;
    endtask
    task automatic send_stop();
        stop_i = 1; @(negedge clk); stop_i = 0;
    endtask
    task automatic wait_prog(output int cyc);
        cyc = 0;
        while (busy_o) begin cyc++; @(negedge clk); end
        @(negedge clk);
    endtask

    task automatic do_write(input logic md, input logic [10:0] a, input int n,
                            input logic [7:0] seed, output int acks, output int cyc);
        mode_i = md; acks = 0;
        send_start();
        send_addr(a);
        for (int i = 0; i < n; i++) begin
            if (ack_ok_o) acks++;
            send_data(8'(seed + i));
        end
        send_stop();
        wait_prog(cyc);
    endtask

    task automatic t_reset();
        chk_eq("R1 busy", busy_o, 0);
        chk_eq("R1 ack", ack_ok_o, 0);
        chk_eq("R1 we", mem_we_o, 0);
    endtask

    task automatic t_page_wrap();
        int acks, cyc, w0;
        w0 = n_wr;
        do_write(1'b0, 11'h12E, 18, 8'h40, acks, cyc);
        chk_eq("R2 wrap slot E", mdl[11'h12E], 8'h50);
        chk_eq("R2 wrap slot F", mdl[11'h12F], 8'h51);
        chk_eq("R2 slot 0", mdl[11'h120], 8'h42);
        chk_eq("R2 slot D", mdl[11'h12D], 8'h4F);
        chk_eq("R2 next row untouched", mdl[11'h130], 8'hFF);
        chk_eq("R2 write count", n_wr - w0, 16);
        chk_eq("R3 busy length", cyc, P);
    endtask

    task automatic t_burst_cross();
        int acks, cyc, w0;
        w0 = n_wr;
        do_write(1'b1, 11'h20C, 10, 8'h60, acks, cyc);
        chk_eq("R5 all bytes acked", acks, 10);
        chk_eq("R4 first", mdl[11'h20C], 8'h60);
        chk_eq("R4 crosses row", mdl[11'h210], 8'h64);
        chk_eq("R4 eighth", mdl[11'h213], 8'h67);
        chk_eq("R5 ninth dropped", mdl[11'h214], 8'hFF);
        chk_eq("R5 tenth dropped", mdl[11'h215], 8'hFF);
        chk_eq("R5 write count", n_wr - w0, 8);
        chk_eq("R4 double time", cyc, 2 * P);
    endtask

    task automatic t_burst_in_row();
        int acks, cyc;
        do_write(1'b1, 11'h300, 3, 8'h80, acks, cyc);
        chk_eq("R4 no cross single time", cyc, P);
        chk_eq("R4 third byte", mdl[11'h302], 8'h82);
    endtask

    task automatic t_single();
        int acks, cyc;
        do_write(1'b0, 11'h0A1, 1, 8'h5A, acks, cyc);
        chk_eq("R6 row mode byte", mdl[11'h0A1], 8'h5A);
        chk_eq("R6 row mode time", cyc, P);
        do_write(1'b1, 11'h0B1, 1, 8'hA5, acks, cyc);
        chk_eq("R6 burst mode byte", mdl[11'h0B1], 8'hA5);
        chk_eq("R6 burst mode time", cyc, P);
    endtask

    task automatic t_wc();
        int cyc, w0;
        w0 = n_wr;
        mode_i = 0;
        wc_i = 1; send_start(); wc_i = 0;
        send_addr(11'h150);
        chk_eq("R7 no ack after START inhibit", ack_ok_o, 0);
        send_data(8'h11); send_stop(); wait_prog(cyc);
        chk_eq("R7 no cycle", cyc, 0);
        send_start();
        wc_i = 1; send_addr(11'h151); wc_i = 0;
        chk_eq("R7 no ack after address inhibit", ack_ok_o, 0);
        send_data(8'h12); send_stop(); wait_prog(cyc);
        chk_eq("R7 no writes", n_wr - w0, 0);
        chk_eq("R7 byte kept", mdl[11'h151], 8'hFF);
    endtask

    task automatic t_empty_stop();
        int cyc;
        send_start(); send_addr(11'h160);
        chk_eq("R10 ack in data phase", ack_ok_o, 1);
        send_stop(); wait_prog(cyc);
        chk_eq("R3 empty STOP no cycle", cyc, 0);
    endtask

    task automatic t_protect();
        int acks, cyc;
        pre_i = 0;
        do_write(1'b0, 11'h7FF, 1, 8'h30, acks, cyc);
        chk_eq("R9 pointer writable with pre low", mdl[11'h7FF], 8'h30);
        pb_i = 2'b01; pre_i = 1;
        do_write(1'b1, 11'h52E, 4, 8'h70, acks, cyc);
        chk_eq("R8 below floor", mdl[11'h52E], 8'h70);
        chk_eq("R8 just below floor", mdl[11'h52F], 8'h71);
        chk_eq("R8 floor dropped", mdl[11'h530], 8'hFF);
        chk_eq("R8 above floor dropped", mdl[11'h531], 8'hFF);
        do_write(1'b0, 11'h7FF, 1, 8'h99, acks, cyc);
        chk_eq("R8 top protected", mdl[11'h7FF], 8'h30);
        pb_i = 2'b11;
        do_write(1'b1, 11'h530, 1, 8'h11, acks, cyc);
        chk_eq("R8 block select moves floor", mdl[11'h530], 8'h11);
        do_write(1'b1, 11'h731, 1, 8'h12, acks, cyc);
        chk_eq("R8 block 7 floor", mdl[11'h731], 8'hFF);
        pre_i = 0;
        do_write(1'b0, 11'h7FF, 1, 8'h34, acks, cyc);
        chk_eq("R9 pointer rewritten", mdl[11'h7FF], 8'h34);
        pre_i = 1; pb_i = 2'b01;
        do_write(1'b1, 11'h531, 1, 8'h22, acks, cyc);
        chk_eq("R9 flag set disables protection", mdl[11'h531], 8'h22);
        pre_i = 0;
    endtask

    task automatic t_busy_ignore();
        int cyc, w0;
        w0 = n_wr;
        mode_i = 1;
        send_start(); send_addr(11'h400); send_data(8'h33); send_stop();
        chk_eq("R10 busy", busy_o, 1);
        send_start(); send_addr(11'h401);
        chk_eq("R10 no ack while busy", ack_ok_o, 0);
        send_data(8'h44); send_stop();
        wait_prog(cyc);
        chk_eq("R10 stays idle", busy_o, 0);
        chk_eq("R10 busy strobes ignored", mdl[11'h401], 8'hFF);
        chk_eq("R10 one write", n_wr - w0, 1);
    endtask

    task automatic t_restart();
        int cyc;
        mode_i = 0;
        send_start(); send_addr(11'h600); send_data(8'h77);
        send_start(); send_addr(11'h610); send_stop();
        wait_prog(cyc);
        chk_eq("R11 dummy write no cycle", cyc, 0);
        chk_eq("R11 byte discarded", mdl[11'h600], 8'hFF);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_page_wrap();
        t_burst_cross();
        t_burst_in_row();
        t_single();
        t_wc();
        t_empty_stop();
        t_protect();
        t_busy_ignore();
        t_restart();
        done = 1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            report();
        end
    end
endmodule